// File: doc/BRIEF.md
# Serial Flash Sector Lock Controller

This block is the slave-side logic of a serial NOR flash model that holds a two-bit volatile lock entry for every sector. It listens on a serial bus made of chip select, serial clock and four bidirectional data lines. The bus runs one, two or four bits per clock, as chosen by a mode input. The block understands three commands: one sets a write-enable latch, one writes the lock entry of the sector that an address points into, and one reads that entry back. Every other opcode is ignored.

Bit 0 of each entry protects the sector against program and erase. Bit 1 freezes the entry until the next reset. A per-sector allow vector goes to the array controller. A write takes effect only in these conditions:

- The write-enable latch was set by an earlier command.
- The frame ends with chip select rising directly after the eighth data bit.
- The target entry is not frozen.

The serial pins are sampled by the system clock through a small synchronizer. The serial clock must therefore run well below the system clock.

Top module: `seclock_ctrl`

## Requirements
- R1: After reset every lock entry is 0, `pe_allow` is all ones, `wel` is 0 and no data line is driven.
- R2: A frame holding exactly the opcode 0x06 (8 bits, then chip select rises) sets `wel`. A frame with further clocks after that opcode leaves `wel` unchanged.
- R3: When `wel` is 1, a write frame loads bits 1:0 of its data byte into the entry of the addressed sector and leaves every other sector unchanged. The frame is opcode 0xE5, then a 24-bit address whose bits 23:20 pick the sector, then one data byte, all MSB first. The upper six data bits are discarded.
- R4: A write frame sent while `wel` is 0 changes no entry.
- R5: `pe_allow[i]` is 0 exactly while bit 0 of sector i's entry is 1.
- R6: While bit 1 of a sector's entry is 1, write frames leave that entry unchanged.
- R7: A complete write frame that finds `wel` at 1 clears `wel`, whether or not the entry was frozen.
- R8: A write frame whose chip select rises before the eighth data bit, or after one or more extra clocks, changes no entry and leaves `wel` at 1.
- R9: In single-line mode (`bus_mode` 0), a read frame (opcode 0xE8 plus a 24-bit address) returns the byte {6'b0, entry} on dq[1]. The byte is sent MSB first, one bit per clock, starting with the clock after the 32nd. It repeats while chip select stays low.
- R10: In dual mode (`bus_mode` 1), all frame fields move two bits per clock on dq[1:0], with dq[1] the more significant bit, and read data starts after 16 clocks. In quad mode (`bus_mode` 2), they move four bits per clock on dq[3:0], with dq[3] the most significant bit, and read data starts after 8 clocks.
- R11: The data lines are released whenever chip select is high.
- R12: Frames with any other opcode change neither `wel` nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset that clears all lock state |
| cs_n | input | 1 | Active-low chip select that frames commands |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge and driven after its falling edge |
| dq | inout | 4 | Serial data lines |
| bus_mode | input | 2 | Lines per clock: 0 single, 1 dual, 2 quad (3 acts as single) |
| wel | output | 1 | Write-enable latch |
| pe_allow | output | 16 | Per-sector program/erase allowed |

## Verification
A serial clock or chip select edge reaches the frame decoder three system clocks after the pin changes. The latch and the lock entries are updated two registers later, so they are final about five clocks after chip select rises; the bench waits twelve clocks before it checks them. Read bits leave the output register about four clocks after each falling serial clock edge. The bench holds each serial clock phase for eight system clocks and samples the data lines on the last falling system clock edge before the serial clock rises, so every sample sees settled data.

// File: rtl/seclock_pkg.sv
`timescale 1ns/1ps
package seclock_pkg;

    localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
    localparam logic [7:0] OP_LOCK_WRITE = 8'hE5;
    localparam logic [7:0] OP_LOCK_READ  = 8'hE8;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DATA,
        PH_WR_READY,
        PH_EN_READY,
        PH_READOUT,
        PH_IGNORE
    } frame_phase_e;

    // Number of data lines carrying bits on each serial clock.
    function automatic logic [2:0] lanes_per_clk(input logic [1:0] mode);
        case (mode)
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/seclock_pin_sync.sv
`timescale 1ns/1ps
module seclock_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic [3:0] dq_in,
    output logic       cs_act,
    output logic       cs_rise,
    output logic       sclk_rise,
    output logic       sclk_fall,
    output logic [3:0] dq_s
);

    typedef struct packed {
        logic [STAGES:0]        sclk_pipe;
        logic [STAGES:0]        cs_pipe;
        logic [STAGES-1:0][3:0] dq_pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d            = s_q;
        s_d.sclk_pipe  = {s_q.sclk_pipe[STAGES-1:0], sclk};
        s_d.cs_pipe    = {s_q.cs_pipe[STAGES-1:0], cs_n};
        s_d.dq_pipe[0] = dq_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.dq_pipe[i] = s_q.dq_pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.cs_pipe <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_rise = s_q.sclk_pipe[STAGES-1] & ~s_q.sclk_pipe[STAGES];
    assign sclk_fall = ~s_q.sclk_pipe[STAGES-1] & s_q.sclk_pipe[STAGES];
    assign cs_rise   = s_q.cs_pipe[STAGES-1] & ~s_q.cs_pipe[STAGES];
    assign cs_act    = ~s_q.cs_pipe[STAGES-1];
    assign dq_s      = s_q.dq_pipe[STAGES-1];

endmodule

// File: rtl/seclock_frame_fsm.sv
`timescale 1ns/1ps
module seclock_frame_fsm
    import seclock_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [3:0]        dq_s,
    input  logic [1:0]        mode,
    input  logic [1:0]        rd_entry,
    output logic              en_pulse,
    output logic              wr_pulse,
    output logic [SECT_W-1:0] sector,
    output logic [1:0]        wr_val,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe
);

    localparam int CNT_W = $clog2(ADDR_W + 1);

    typedef struct packed {
        frame_phase_e      phase;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] shreg;
        logic              is_read;
        logic [SECT_W-1:0] sector;
        logic [1:0]        wr_val;
        logic [2:0]        rd_ptr;
        logic [3:0]        out;
        logic [3:0]        oe;
        logic              en_pulse;
        logic              wr_pulse;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [2:0]        step;
    logic [ADDR_W-1:0] shifted;
    logic [CNT_W-1:0]  cnt_next;
    logic [7:0]        rd_byte;

    always_comb begin
        f_d          = f_q;
        f_d.en_pulse = 1'b0;
        f_d.wr_pulse = 1'b0;
        step         = lanes_per_clk(mode);
        cnt_next     = f_q.cnt + CNT_W'(step);
        rd_byte      = {6'b0, rd_entry} << f_q.rd_ptr;
        case (mode)
            2'd1:    shifted = {f_q.shreg[ADDR_W-3:0], dq_s[1:0]};
            2'd2:    shifted = {f_q.shreg[ADDR_W-5:0], dq_s[3:0]};
            default: shifted = {f_q.shreg[ADDR_W-2:0], dq_s[0]};
        endcase

        // A frame ends at the rising edge of chip select.
        if (cs_rise) begin
            if (f_q.phase == PH_WR_READY) f_d.wr_pulse = 1'b1;
            if (f_q.phase == PH_EN_READY) f_d.en_pulse = 1'b1;
        end

        if (!cs_act) begin
            f_d.phase  = PH_OPCODE;
            f_d.cnt    = '0;
            f_d.out    = '0;
            f_d.oe     = '0;
            f_d.rd_ptr = '0;
        end else if (sclk_rise) begin
            case (f_q.phase)
                PH_OPCODE: begin
                    f_d.shreg = shifted;
                    f_d.cnt   = cnt_next;
                    if (cnt_next == CNT_W'(8)) begin
                        f_d.cnt = '0;
                        case (shifted[7:0])
                            OP_WR_ENABLE:  f_d.phase = PH_EN_READY;
                            OP_LOCK_WRITE: begin
                                f_d.phase   = PH_ADDR;
                                f_d.is_read = 1'b0;
                            end
                            OP_LOCK_READ:  begin
                                f_d.phase   = PH_ADDR;
                                f_d.is_read = 1'b1;
                            end
                            default:       f_d.phase = PH_IGNORE;
                        endcase
                    end
                end
                PH_ADDR: begin
                    f_d.shreg = shifted;
                    f_d.cnt   = cnt_next;
                    if (cnt_next == CNT_W'(ADDR_W)) begin
                        f_d.cnt    = '0;
                        f_d.sector = shifted[ADDR_W-1 -: SECT_W];
                        f_d.phase  = f_q.is_read ? PH_READOUT : PH_DATA;
                    end
                end
                PH_DATA: begin
                    f_d.shreg = shifted;
                    f_d.cnt   = cnt_next;
                    if (cnt_next == CNT_W'(8)) begin
                        f_d.cnt    = '0;
                        f_d.wr_val = shifted[1:0];
                        f_d.phase  = PH_WR_READY;
                    end
                end
                // Any clock past a finished frame spoils it.
                PH_WR_READY, PH_EN_READY: f_d.phase = PH_IGNORE;
                default: ;
            endcase
        end else if (sclk_fall && f_q.phase == PH_READOUT) begin
            case (mode)
                2'd1: begin
                    f_d.out = {2'b00, rd_byte[7:6]};
                    f_d.oe  = 4'b0011;
                end
                2'd2: begin
                    f_d.out = rd_byte[7:4];
                    f_d.oe  = 4'b1111;
                end
                default: begin
                    f_d.out = {2'b00, rd_byte[7], 1'b0};
                    f_d.oe  = 4'b0010;
                end
            endcase
            f_d.rd_ptr = f_q.rd_ptr + step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.phase <= PH_OPCODE;
        end else begin
            f_q <= f_d;
        end
    end

    assign en_pulse = f_q.en_pulse;
    assign wr_pulse = f_q.wr_pulse;
    assign sector   = f_q.sector;
    assign wr_val   = f_q.wr_val;
    assign dq_out   = f_q.out;
    assign dq_oe    = f_q.oe;

endmodule

// File: rtl/seclock_entry_bank.sv
`timescale 1ns/1ps
module seclock_entry_bank #(
    parameter  int SECT_W = 4,
    localparam int NSECT  = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pulse,
    input  logic              wr_pulse,
    input  logic [SECT_W-1:0] wr_sector,
    input  logic [1:0]        wr_val,
    output logic [2*NSECT-1:0] entries,
    output logic              wel,
    output logic [NSECT-1:0]  pe_allow
);

    typedef struct packed {
        logic [NSECT-1:0][1:0] ent;
        logic                  wel;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (en_pulse) b_d.wel = 1'b1;
        if (wr_pulse && b_q.wel) begin
            b_d.wel = 1'b0;
            if (!b_q.ent[wr_sector][1]) b_d.ent[wr_sector] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign entries[2*g +: 2] = b_q.ent[g];
        assign pe_allow[g]       = ~b_q.ent[g][0];
    end

    assign wel = b_q.wel;

endmodule

// File: rtl/seclock_ctrl.sv
`timescale 1ns/1ps
module seclock_ctrl #(
    parameter  int ADDR_W      = 24,
    parameter  int SECT_W      = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int NSECT       = 1 << SECT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    inout  wire  [3:0]       dq,
    input  logic [1:0]       bus_mode,
    output logic             wel,
    output logic [NSECT-1:0] pe_allow
);

    logic              cs_act, cs_rise, sclk_rise, sclk_fall;
    logic [3:0]        dq_s, dq_out, dq_oe;
    logic              en_pulse, wr_pulse;
    logic [SECT_W-1:0] sector;
    logic [1:0]        wr_val, rd_entry;
    logic [2*NSECT-1:0] entries;

    seclock_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .dq_in     (dq),
        .cs_act    (cs_act),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .dq_s      (dq_s)
    );

    seclock_frame_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .dq_s      (dq_s),
        .mode      (bus_mode),
        .rd_entry  (rd_entry),
        .en_pulse  (en_pulse),
        .wr_pulse  (wr_pulse),
        .sector    (sector),
        .wr_val    (wr_val),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    seclock_entry_bank #(.SECT_W(SECT_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_pulse  (en_pulse),
        .wr_pulse  (wr_pulse),
        .wr_sector (sector),
        .wr_val    (wr_val),
        .entries   (entries),
        .wel       (wel),
        .pe_allow  (pe_allow)
    );

    assign rd_entry = entries[2*sector +: 2];

    for (genvar i = 0; i < 4; i++) begin : g_pad
        assign dq[i] = dq_oe[i] ? dq_out[i] : 1'bz;
    end

endmodule

// File: rtl/seclock_ctrl_chk.sv
`timescale 1ns/1ps
module seclock_ctrl_chk #(
    parameter int NSECT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_act,
    input logic               en_pulse,
    input logic               wr_pulse,
    input logic               wel,
    input logic [3:0]         dq_oe,
    input logic [2*NSECT-1:0] entries,
    input logic [NSECT-1:0]   pe_allow
);

    // R2
    wren_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_pulse |=> wel);

    // R7
    write_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wel) |=> !wel);

    // R4
    no_latch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !wel) |=> $stable(entries));

    // R3
    entry_change_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(entries) |-> $past(wr_pulse && wel));

    // R5
    allow_change_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pe_allow) |-> $past(wr_pulse));

    // R11
    release_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (dq_oe == 4'b0000));

    // R12
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_pulse, wr_pulse}));

    for (genvar g = 0; g < NSECT; g++) begin : g_frz
        // R6
        lockdown_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            entries[2*g+1] |=> $stable(entries[2*g +: 2]));
    end

endmodule

bind seclock_ctrl seclock_ctrl_chk #(.NSECT(NSECT)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .en_pulse (en_pulse),
    .wr_pulse (wr_pulse),
    .wel      (wel),
    .dq_oe    (dq_oe),
    .entries  (entries),
    .pe_allow (pe_allow)
);

// File: tb/seclock_ctrl_tb_top.sv
`timescale 1ns/1ps
module seclock_ctrl_tb_top;

    localparam int HALF  = 8;
    localparam int NSECT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic [1:0] bus_mode = 2'd0;
    logic [3:0] tb_drv = 4'h0;
    logic [3:0] tb_oe = 4'h0;
    wire  [3:0] dq;
    logic wel;
    logic [NSECT-1:0] pe_allow;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < 4; i++) begin : g_drv
        assign dq[i] = tb_oe[i] ? tb_drv[i] : 1'bz;
    end

    seclock_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .dq       (dq),
        .bus_mode (bus_mode),
        .wel      (wel),
        .pe_allow (pe_allow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int lw();
        case (bus_mode)
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 1;
        endcase
    endfunction

    task automatic shift_out(input logic [31:0] val, input int nbits);
        int w = lw();
        logic [3:0] mask = (w == 1) ? 4'h1 : (w == 2) ? 4'h3 : 4'hF;
        for (int k = nbits - w; k >= 0; k -= w) begin
            tb_oe  = mask;
            tb_drv = 4'(val >> k) & mask;
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic frame_start();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic frame_end();
        wait_clk(HALF);
        cs_n  = 1'b1;
        tb_oe = 4'h0;
        wait_clk(12);
    endtask

    task automatic send_wren();
        frame_start();
        shift_out(32'h06, 8);
        frame_end();
    endtask

    task automatic send_lock(input logic [23:0] addr, input logic [7:0] data,
                             input int data_bits, input int extra_bits);
        frame_start();
        shift_out(32'hE5, 8);
        shift_out({8'h0, addr}, 24);
        shift_out({24'h0, data} >> (8 - data_bits), data_bits);
        if (extra_bits > 0) shift_out(32'h0, extra_bits);
        frame_end();
    endtask

    task automatic read_lock(input logic [23:0] addr, input int nbytes, output logic [15:0] got);
        int w = lw();
        got = '0;
        frame_start();
        shift_out(32'hE8, 8);
        shift_out({8'h0, addr}, 24);
        tb_oe = 4'h0;
        for (int c = 0; c < nbytes * 8 / w; c++) begin
            wait_clk(HALF);
            case (w)
                2:       got = {got[13:0], dq[1:0]};
                4:       got = {got[11:0], dq[3:0]};
                default: got = {got[14:0], dq[1]};
            endcase
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        frame_end();
    endtask

    task automatic t_reset();
        logic [15:0] rb;
        chk("R1 pe_allow after reset", 32'(pe_allow), 32'hFFFF);
        chk("R1 wel after reset", 32'(wel), 32'h0);
        read_lock(24'h5F_0000, 2, rb);
        chk("R1 R9 cleared entry reads 0", 32'(rb), 32'h0000);
    endtask

    task automatic t_wren();
        frame_start();
        shift_out(32'h0600, 16);
        frame_end();
        chk("R2 long enable frame ignored", 32'(wel), 32'h0);
        send_wren();
        chk("R2 enable sets wel", 32'(wel), 32'h1);
    endtask

    task automatic t_write_basic();
        logic [15:0] rb;
        send_lock(24'h3A_BC12, 8'hFD, 8, 0);
        chk("R3 R5 sector 3 protected", 32'(pe_allow), 32'hFFF7);
        chk("R7 wel cleared", 32'(wel), 32'h0);
        read_lock(24'h30_0000, 2, rb);
        chk("R9 readback repeats, upper bits zero", 32'(rb), 32'h0101);
    endtask

    task automatic t_no_wel();
        send_lock(24'h70_0000, 8'h01, 8, 0);
        chk("R4 write without wel ignored", 32'(pe_allow), 32'hFFF7);
    endtask

    task automatic t_lockdown();
        logic [15:0] rb;
        send_wren();
        send_lock(24'h91_2345, 8'h03, 8, 0);
        chk("R3 sector 9 locked down", 32'(pe_allow), 32'hFDF7);
        send_wren();
        send_lock(24'h9F_FFFF, 8'h00, 8, 0);
        chk("R6 frozen entry kept", 32'(pe_allow), 32'hFDF7);
        chk("R7 wel cleared on frozen write", 32'(wel), 32'h0);
        read_lock(24'h90_0000, 1, rb);
        chk("R6 frozen entry reads 03", 32'(rb), 32'h0003);
    endtask

    task automatic t_abort();
        send_wren();
        send_lock(24'h20_0000, 8'h01, 5, 0);
        chk("R8 short data no change", 32'(pe_allow), 32'hFDF7);
        chk("R8 short data keeps wel", 32'(wel), 32'h1);
        send_lock(24'h20_0000, 8'h01, 8, 1);
        chk("R8 extra clock no change", 32'(pe_allow), 32'hFDF7);
        chk("R8 extra clock keeps wel", 32'(wel), 32'h1);
        send_lock(24'h20_0000, 8'h00, 8, 0);
        chk("R7 valid write clears wel", 32'(wel), 32'h0);
    endtask

    task automatic t_other();
        send_wren();
        frame_start();
        shift_out(32'h9F, 8);
        shift_out(32'h30_0000, 24);
        shift_out(32'h00, 8);
        frame_end();
        chk("R12 other opcode keeps wel", 32'(wel), 32'h1);
        chk("R12 other opcode keeps entries", 32'(pe_allow), 32'hFDF7);
    endtask

    task automatic t_dual();
        logic [15:0] rb;
        bus_mode = 2'd1;
        send_wren();
        send_lock(24'hC0_0000, 8'h01, 8, 0);
        chk("R10 dual write sector 12", 32'(pe_allow), 32'hEDF7);
        chk("R10 dual write clears wel", 32'(wel), 32'h0);
        read_lock(24'hC0_0000, 2, rb);
        chk("R10 dual readback", 32'(rb), 32'h0101);
        read_lock(24'h9A_0000, 1, rb);
        chk("R10 dual readback frozen sector", 32'(rb), 32'h0003);
    endtask

    task automatic t_quad();
        logic [15:0] rb;
        bus_mode = 2'd2;
        send_wren();
        send_lock(24'hF0_0001, 8'h01, 8, 0);
        chk("R10 quad write sector 15", 32'(pe_allow), 32'h6DF7);
        read_lock(24'hF0_0000, 2, rb);
        chk("R10 quad readback", 32'(rb), 32'h0101);
        read_lock(24'h00_0000, 1, rb);
        chk("R10 quad readback sector 0", 32'(rb), 32'h0000);
        read_lock(24'h3F_0000, 1, rb);
        chk("R10 quad readback sector 3", 32'(rb), 32'h0001);
        bus_mode = 2'd0;
    endtask

    task automatic t_release();
        tb_oe  = 4'hF;
        tb_drv = 4'hA;
        wait_clk(3);
        chk("R11 lines free pattern A", 32'(dq), 32'hA);
        tb_drv = 4'h5;
        wait_clk(3);
        chk("R11 lines free pattern 5", 32'(dq), 32'h5);
        tb_oe = 4'h0;
    endtask

    initial begin
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_wren();
        t_write_basic();
        t_no_wel();
        t_lockdown();
        t_abort();
        t_other();
        t_dual();
        t_quad();
        t_release();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule